// File: doc/BRIEF.md
# Bridge Downstream Window Decoder

This block decides whether a transaction seen on the upstream side of a bus-to-bus bridge must be claimed and passed downstream. It rebuilds four kinds of windows from raw configuration fields: an I/O window at 4 KB granularity with an optional 32-bit extension, a non-prefetchable memory window at 1 MB granularity, a prefetchable memory window at 1 MB granularity with an optional 64-bit extension, and the fixed legacy display ranges. It then compares the request address against every window that applies to the request's space.

Each window is gated by its own enable. The I/O enable gates the I/O window, the memory enable gates both memory windows, and the display-forward bit gates the legacy ranges. The result is registered. The block has two output conditions. In the idle condition all outputs are zero; this holds in reset and in any cycle after a cycle with no request. In the result condition, one cycle after a valid request, the block shows one claim bit and a one-hot window code. The block moves to the result condition on every clock edge that samples a valid request, and it returns to idle on an edge that samples no request or on reset.

Top module: `brwin_decoder`

## Requirements
- R1: While `rst_n` is low, `hit_valid`, `hit_claim` and `hit_window` are all zero.
- R2: The decode of a request sampled at a rising edge appears right after that edge. `hit_valid` equals the previous cycle's `req_valid`. After a cycle without a request, `hit_claim` and `hit_window` are zero.
- R3: The I/O window runs from `{io_base_reg[7:4], 12'h000}` to `{io_limit_reg[7:4], 12'hFFF}`. When `io_base_reg[0]` is 1, `io_base_hi` and `io_limit_hi` supply address bits 31:16 of the base and the limit; otherwise those bits are zero.
- R4: The non-prefetchable memory window runs from `{mem_base_reg[15:4], 20'h00000}` to `{mem_limit_reg[15:4], 20'hFFFFF}`, with address bits 63:32 zero.
- R5: The prefetchable window is built the same way from `pf_base_reg` and `pf_limit_reg`. When `pf_base_reg[0]` is 1, `pf_base_hi` and `pf_limit_hi` supply address bits 63:32 of the base and the limit; otherwise those bits are zero.
- R6: When `cmd_io_en` is 0, the I/O window claims nothing. When `cmd_mem_en` is 0, neither memory window claims anything.
- R7: A window whose limit is below its base is empty, and no address hits it.
- R8: When `vga_en` is 1, memory addresses 0xA0000–0xBFFFF and I/O addresses 0x3B0–0x3BB and 0x3C0–0x3DF are claimed. When `vga_en` is 0, these ranges are claimed only through the ordinary windows.
- R9: `hit_window` is one-hot or zero, with bit 0 = I/O, bit 1 = memory, bit 2 = prefetchable, bit 3 = legacy display memory, bit 4 = legacy display I/O. Priority order is prefetchable over memory over display memory, and I/O window over display I/O. `hit_claim` is 1 exactly when a window bit is set.
- R10: A request with `req_is_io` = 1 can hit only the I/O and display-I/O windows. A request with `req_is_io` = 0 can hit only the three memory windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_is_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | 64 | Request address |
| cmd_io_en | input | 1 | I/O window enable |
| cmd_mem_en | input | 1 | Memory windows enable |
| vga_en | input | 1 | Legacy display ranges forward enable |
| io_base_reg | input | 8 | I/O base field (bit 0 = 32-bit type) |
| io_limit_reg | input | 8 | I/O limit field |
| io_base_hi | input | 16 | I/O base bits 31:16 |
| io_limit_hi | input | 16 | I/O limit bits 31:16 |
| mem_base_reg | input | 16 | Memory base field |
| mem_limit_reg | input | 16 | Memory limit field |
| pf_base_reg | input | 16 | Prefetchable base field (bit 0 = 64-bit type) |
| pf_limit_reg | input | 16 | Prefetchable limit field |
| pf_base_hi | input | 32 | Prefetchable base bits 63:32 |
| pf_limit_hi | input | 32 | Prefetchable limit bits 63:32 |
| hit_valid | output | 1 | Registered request valid |
| hit_claim | output | 1 | Request is claimed for downstream |
| hit_window | output | 5 | One-hot matched window |

## Verification
The only state is the result register, so a fault in it shows at the ports within a single cycle. A stale result shows as a claim after an idle cycle. A lost request shows as a dropped `hit_valid`. Bound faults show as a wrong claim one cycle after a request placed exactly on a window edge or one unit past it. The bench therefore probes both edges of every window, across both type encodings, and checks each clock against a behavioural model of the bounds.

// File: rtl/brwin_pkg.sv
package brwin_pkg;
    localparam int ADDR_W    = 64;
    localparam int WIN_N     = 5;
    localparam int IO_GRAN   = 12;
    localparam int MEM_GRAN  = 20;
    localparam int IO_REG_W  = 8;
    localparam int MEM_REG_W = 16;
    localparam int IO_HI_W   = 16;
    localparam int PF_HI_W   = 32;
    localparam int NRANGE    = 6;

    // window code bit positions (one-hot output)
    localparam int W_IO    = 0;
    localparam int W_MEM   = 1;
    localparam int W_PREF  = 2;
    localparam int W_VGAM  = 3;
    localparam int W_VGAIO = 4;

    // comparator slots
    localparam int S_IO  = 0;
    localparam int S_MEM = 1;
    localparam int S_PF  = 2;
    localparam int S_VM  = 3;
    localparam int S_VI0 = 4;
    localparam int S_VI1 = 5;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WIN_N-1:0]  win_t;

    localparam addr_t VGA_MEM_LO = 64'h0000_0000_000A_0000;
    localparam addr_t VGA_MEM_HI = 64'h0000_0000_000B_FFFF;
    localparam addr_t VGA_IO0_LO = 64'h0000_0000_0000_03B0;
    localparam addr_t VGA_IO0_HI = 64'h0000_0000_0000_03BB;
    localparam addr_t VGA_IO1_LO = 64'h0000_0000_0000_03C0;
    localparam addr_t VGA_IO1_HI = 64'h0000_0000_0000_03DF;
endpackage

// File: rtl/brwin_io_bounds.sv
module brwin_io_bounds
    import brwin_pkg::*;
(
    input  logic [IO_REG_W-1:0] base_reg,
    input  logic [IO_REG_W-1:0] limit_reg,
    input  logic [IO_HI_W-1:0]  base_hi,
    input  logic [IO_HI_W-1:0]  limit_hi,
    output addr_t               lo,
    output addr_t               hi
);
    localparam int TOP = IO_GRAN + (IO_REG_W - 4);

    logic wide;
    logic unused_io_bits;

    assign wide           = base_reg[0];
    assign unused_io_bits = ^{base_reg[3:1], limit_reg[3:0]};

    always_comb begin
        lo = '0;
        hi = '0;
        hi[IO_GRAN-1:0]   = '1;
        lo[TOP-1:IO_GRAN] = base_reg[IO_REG_W-1:4];
        hi[TOP-1:IO_GRAN] = limit_reg[IO_REG_W-1:4];
        if (wide) begin
            lo[TOP+IO_HI_W-1:TOP] = base_hi;
            hi[TOP+IO_HI_W-1:TOP] = limit_hi;
        end
    end
endmodule

// File: rtl/brwin_mem_bounds.sv
module brwin_mem_bounds
    import brwin_pkg::*;
#(
    parameter bit HAS_UPPER = 1'b0
) (
    input  logic [MEM_REG_W-1:0] base_reg,
    input  logic [MEM_REG_W-1:0] limit_reg,
    input  logic [PF_HI_W-1:0]   base_up,
    input  logic [PF_HI_W-1:0]   limit_up,
    output addr_t                lo,
    output addr_t                hi
);
    localparam int TOP = MEM_GRAN + (MEM_REG_W - 4);

    logic wide;
    logic unused_mem_bits;

    generate
        if (HAS_UPPER) begin : g_upper
            assign wide            = base_reg[0];
            assign unused_mem_bits = ^{base_reg[3:1], limit_reg[3:0]};
        end else begin : g_flat
            assign wide            = 1'b0;
            assign unused_mem_bits = ^{base_reg[3:0], limit_reg[3:0], base_up, limit_up};
        end
    endgenerate

    always_comb begin
        lo = '0;
        hi = '0;
        hi[MEM_GRAN-1:0]   = '1;
        lo[TOP-1:MEM_GRAN] = base_reg[MEM_REG_W-1:4];
        hi[TOP-1:MEM_GRAN] = limit_reg[MEM_REG_W-1:4];
        if (wide) begin
            lo[TOP+PF_HI_W-1:TOP] = base_up;
            hi[TOP+PF_HI_W-1:TOP] = limit_up;
        end
    end
endmodule

// File: rtl/brwin_range_hit.sv
module brwin_range_hit #(
    parameter int W = 64
) (
    input  logic [W-1:0] addr,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    input  logic         en,
    output logic         hit
);
    // an inverted window (hi < lo) cannot satisfy both compares
    assign hit = en && (addr >= lo) && (addr <= hi);
endmodule

// File: rtl/brwin_decoder.sv
module brwin_decoder
    import brwin_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_is_io,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 cmd_io_en,
    input  logic                 cmd_mem_en,
    input  logic                 vga_en,
    input  logic [IO_REG_W-1:0]  io_base_reg,
    input  logic [IO_REG_W-1:0]  io_limit_reg,
    input  logic [IO_HI_W-1:0]   io_base_hi,
    input  logic [IO_HI_W-1:0]   io_limit_hi,
    input  logic [MEM_REG_W-1:0] mem_base_reg,
    input  logic [MEM_REG_W-1:0] mem_limit_reg,
    input  logic [MEM_REG_W-1:0] pf_base_reg,
    input  logic [MEM_REG_W-1:0] pf_limit_reg,
    input  logic [PF_HI_W-1:0]   pf_base_hi,
    input  logic [PF_HI_W-1:0]   pf_limit_hi,
    output logic                 hit_valid,
    output logic                 hit_claim,
    output logic [WIN_N-1:0]     hit_window
);
    addr_t io_lo, io_hi, mem_lo, mem_hi, pf_lo, pf_hi;
    addr_t rng_lo [NRANGE];
    addr_t rng_hi [NRANGE];
    logic [NRANGE-1:0] rng_en;
    logic [NRANGE-1:0] rng_hit;
    win_t win_nxt;

    brwin_io_bounds u_io (
        .base_reg (io_base_reg),
        .limit_reg(io_limit_reg),
        .base_hi  (io_base_hi),
        .limit_hi (io_limit_hi),
        .lo       (io_lo),
        .hi       (io_hi)
    );

    brwin_mem_bounds #(.HAS_UPPER(1'b0)) u_mem (
        .base_reg (mem_base_reg),
        .limit_reg(mem_limit_reg),
        .base_up  ('0),
        .limit_up ('0),
        .lo       (mem_lo),
        .hi       (mem_hi)
    );

    brwin_mem_bounds #(.HAS_UPPER(1'b1)) u_pf (
        .base_reg (pf_base_reg),
        .limit_reg(pf_limit_reg),
        .base_up  (pf_base_hi),
        .limit_up (pf_limit_hi),
        .lo       (pf_lo),
        .hi       (pf_hi)
    );

    always_comb begin
        rng_lo[S_IO]  = io_lo;       rng_hi[S_IO]  = io_hi;
        rng_lo[S_MEM] = mem_lo;      rng_hi[S_MEM] = mem_hi;
        rng_lo[S_PF]  = pf_lo;       rng_hi[S_PF]  = pf_hi;
        rng_lo[S_VM]  = VGA_MEM_LO;  rng_hi[S_VM]  = VGA_MEM_HI;
        rng_lo[S_VI0] = VGA_IO0_LO;  rng_hi[S_VI0] = VGA_IO0_HI;
        rng_lo[S_VI1] = VGA_IO1_LO;  rng_hi[S_VI1] = VGA_IO1_HI;

        rng_en[S_IO]  = cmd_io_en  &&  req_is_io;
        rng_en[S_MEM] = cmd_mem_en && !req_is_io;
        rng_en[S_PF]  = cmd_mem_en && !req_is_io;
        rng_en[S_VM]  = vga_en     && !req_is_io;
        rng_en[S_VI0] = vga_en     &&  req_is_io;
        rng_en[S_VI1] = vga_en     &&  req_is_io;
    end

    generate
        for (genvar g = 0; g < NRANGE; g++) begin : g_rng
            brwin_range_hit #(.W(ADDR_W)) u_hit (
                .addr(req_addr),
                .lo  (rng_lo[g]),
                .hi  (rng_hi[g]),
                .en  (rng_en[g]),
                .hit (rng_hit[g])
            );
        end
    endgenerate

    // priority select: prefetchable > memory > display memory; io > display io
    always_comb begin
        win_nxt = '0;
        if (req_is_io) begin
            if (rng_hit[S_IO])
                win_nxt[W_IO] = 1'b1;
            else if (rng_hit[S_VI0] || rng_hit[S_VI1])
                win_nxt[W_VGAIO] = 1'b1;
        end else begin
            if (rng_hit[S_PF])
                win_nxt[W_PREF] = 1'b1;
            else if (rng_hit[S_MEM])
                win_nxt[W_MEM] = 1'b1;
            else if (rng_hit[S_VM])
                win_nxt[W_VGAM] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_valid  <= 1'b0;
            hit_claim  <= 1'b0;
            hit_window <= '0;
        end else begin
            hit_valid  <= req_valid;
            hit_claim  <= req_valid && (win_nxt != '0);
            hit_window <= req_valid ? win_nxt : '0;
        end
    end
endmodule

// File: rtl/brwin_decoder_chk.sv
module brwin_decoder_chk
    import brwin_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_is_io,
    input logic             cmd_io_en,
    input logic             cmd_mem_en,
    input logic             vga_en,
    input logic             hit_valid,
    input logic             hit_claim,
    input logic [WIN_N-1:0] hit_window
);
    // R2
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!hit_valid && !hit_claim && hit_window == '0));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> hit_valid);

    // R9
    onehot_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_window) && (hit_claim == (hit_window != '0)));

    // R6
    io_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_io && !cmd_io_en) |=> !hit_window[W_IO]);

    // R6
    mem_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_io && !cmd_mem_en) |=> (!hit_window[W_MEM] && !hit_window[W_PREF]));

    // R8
    vga_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !vga_en) |=> (!hit_window[W_VGAM] && !hit_window[W_VGAIO]));

    // R10
    io_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_io) |=> (!hit_window[W_MEM] && !hit_window[W_PREF] && !hit_window[W_VGAM]));

    // R10
    mem_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_io) |=> (!hit_window[W_IO] && !hit_window[W_VGAIO]));
endmodule

bind brwin_decoder brwin_decoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_is_io (req_is_io),
    .cmd_io_en (cmd_io_en),
    .cmd_mem_en(cmd_mem_en),
    .vga_en    (vga_en),
    .hit_valid (hit_valid),
    .hit_claim (hit_claim),
    .hit_window(hit_window)
);

// File: tb/tb_brwin_decoder.sv
module tb_brwin_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_is_io = 1'b0;
    logic [63:0] req_addr = '0;
    logic        cmd_io_en = 1'b0;
    logic        cmd_mem_en = 1'b0;
    logic        vga_en = 1'b0;
    logic [7:0]  io_base_reg = '0;
    logic [7:0]  io_limit_reg = '0;
    logic [15:0] io_base_hi = '0;
    logic [15:0] io_limit_hi = '0;
    logic [15:0] mem_base_reg = '0;
    logic [15:0] mem_limit_reg = '0;
    logic [15:0] pf_base_reg = '0;
    logic [15:0] pf_limit_reg = '0;
    logic [31:0] pf_base_hi = '0;
    logic [31:0] pf_limit_hi = '0;
    logic        hit_valid, hit_claim;
    logic [4:0]  hit_window;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_tag = "R2";
    string exp_tag = "";
    bit    pend = 1'b0;
    logic       exp_v, exp_c;
    logic [4:0] exp_w;

    always #2.5 clk = ~clk;

    brwin_decoder dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_io(req_is_io),
        .req_addr(req_addr), .cmd_io_en(cmd_io_en), .cmd_mem_en(cmd_mem_en),
        .vga_en(vga_en), .io_base_reg(io_base_reg), .io_limit_reg(io_limit_reg),
        .io_base_hi(io_base_hi), .io_limit_hi(io_limit_hi),
        .mem_base_reg(mem_base_reg), .mem_limit_reg(mem_limit_reg),
        .pf_base_reg(pf_base_reg), .pf_limit_reg(pf_limit_reg),
        .pf_base_hi(pf_base_hi), .pf_limit_hi(pf_limit_hi),
        .hit_valid(hit_valid), .hit_claim(hit_claim), .hit_window(hit_window)
    );

    function automatic bit inside_rng(longint unsigned a, longint unsigned lo, longint unsigned hi);
        return (a >= lo) && (a <= hi);
    endfunction

    // behavioural reference: window code from the requirement formulas
    function automatic logic [4:0] model_win();
        longint unsigned a = req_addr;
        longint unsigned io_lo, io_hi, m_lo, m_hi, p_lo, p_hi;
        longint unsigned mb = 64'h10_0000;
        io_lo = longint'(io_base_reg >> 4) * 4096;
        io_hi = longint'(io_limit_reg >> 4) * 4096 + 4095;
        if (io_base_reg % 2 == 1) begin
            io_lo += longint'(io_base_hi) * 65536;
            io_hi += longint'(io_limit_hi) * 65536;
        end
        m_lo = longint'(mem_base_reg >> 4) * mb;
        m_hi = longint'(mem_limit_reg >> 4) * mb + mb - 1;
        p_lo = longint'(pf_base_reg >> 4) * mb;
        p_hi = longint'(pf_limit_reg >> 4) * mb + mb - 1;
        if (pf_base_reg % 2 == 1) begin
            p_lo += longint'(pf_base_hi) << 32;
            p_hi += longint'(pf_limit_hi) << 32;
        end
        if (req_is_io) begin
            if (cmd_io_en && inside_rng(a, io_lo, io_hi)) return 5'b00001;
            if (vga_en && (inside_rng(a, 'h3B0, 'h3BB) || inside_rng(a, 'h3C0, 'h3DF))) return 5'b10000;
            return 5'b00000;
        end
        if (cmd_mem_en && inside_rng(a, p_lo, p_hi)) return 5'b00100;
        if (cmd_mem_en && inside_rng(a, m_lo, m_hi)) return 5'b00010;
        if (vga_en && inside_rng(a, 'hA0000, 'hBFFFF)) return 5'b01000;
        return 5'b00000;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_v = 1'b0; exp_c = 1'b0; exp_w = '0;
        end else begin
            exp_v = req_valid;
            exp_w = req_valid ? model_win() : 5'b0;
            exp_c = (exp_w != 0);
        end
        exp_tag = rst_n ? cur_tag : "R1";
        pend = 1'b1;
    end

    always @(negedge clk) begin
        if (pend && !done) begin
            checks++;
            if (hit_valid !== exp_v || hit_claim !== exp_c || hit_window !== exp_w) begin
                errors++;
                $display("FAIL %s: got v/c/w %b/%b/%b expected %b/%b/%b",
                         exp_tag, hit_valid, hit_claim, hit_window, exp_v, exp_c, exp_w);
            end
        end
    end

    task automatic send(input bit io, input logic [63:0] a, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_is_io = io; req_addr = a; cur_tag = tag;
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        req_valid = 1'b0; cur_tag = tag;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: got hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset holds outputs at zero even with a request present
        req_valid = 1'b1; req_addr = 64'hA0000; vga_en = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        cmd_io_en = 1'b1; cmd_mem_en = 1'b1; vga_en = 1'b0;
        // R3: 16-bit I/O window 0x2000..0x3FFF
        io_base_reg = 8'h20; io_limit_reg = 8'h30;
        send(1, 64'h2000, "R3"); send(1, 64'h3FFF, "R3");
        send(1, 64'h1FFF, "R3"); send(1, 64'h4000, "R3");
        // R3: 32-bit I/O window 0x1_2000..0x1_3FFF
        io_base_reg = 8'h21; io_limit_reg = 8'h31; io_base_hi = 16'h1; io_limit_hi = 16'h1;
        send(1, 64'h12000, "R3"); send(1, 64'h13FFF, "R3"); send(1, 64'h2000, "R3");
        // R6: I/O enable off
        cmd_io_en = 1'b0;
        send(1, 64'h12000, "R6");
        cmd_io_en = 1'b1;
        // R2: idle cycle clears the result
        idle("R2"); idle("R2");
        // R4: memory window 0x1230_0000..0x124F_FFFF
        mem_base_reg = 16'h1230; mem_limit_reg = 16'h1240;
        send(0, 64'h1230_0000, "R4"); send(0, 64'h124F_FFFF, "R4");
        send(0, 64'h122F_FFFF, "R4"); send(0, 64'h1250_0000, "R4");
        send(0, 64'h1_1230_0000, "R4");
        // R10: I/O request at a memory address
        send(1, 64'h1230_0000, "R10");
        // R9: prefetchable overlaps and wins
        pf_base_reg = 16'h1240; pf_limit_reg = 16'h1250;
        send(0, 64'h1240_0000, "R9"); send(0, 64'h1235_0000, "R9");
        // R5: 64-bit prefetchable at 0x1_0010_0000..0x1_002F_FFFF
        pf_base_reg = 16'h0011; pf_limit_reg = 16'h0021; pf_base_hi = 32'h1; pf_limit_hi = 32'h1;
        send(0, 64'h1_0010_0000, "R5"); send(0, 64'h1_002F_FFFF, "R5");
        send(0, 64'h0010_0000, "R5"); send(0, 64'h1_0030_0000, "R5");
        // R7: inverted windows claim nothing
        mem_base_reg = 16'h2000; mem_limit_reg = 16'h1000;
        send(0, 64'h1800_0000, "R7"); send(0, 64'h2000_0000, "R7");
        io_base_reg = 8'h50; io_limit_reg = 8'h40; io_base_hi = 16'h0; io_limit_hi = 16'h0;
        send(1, 64'h5000, "R7"); send(1, 64'h4800, "R7");
        // R6: memory enable off
        mem_base_reg = 16'h1230; mem_limit_reg = 16'h1240;
        cmd_mem_en = 1'b0;
        send(0, 64'h1230_0000, "R6"); send(0, 64'h1_0010_0000, "R6");
        // R8: legacy display ranges
        send(0, 64'hA0000, "R8");
        vga_en = 1'b1;
        send(0, 64'hA0000, "R8"); send(0, 64'hBFFFF, "R8"); send(0, 64'hC0000, "R8");
        send(0, 64'h9FFFF, "R8");
        send(1, 64'h3B0, "R8"); send(1, 64'h3BB, "R8"); send(1, 64'h3BC, "R8");
        send(1, 64'h3C0, "R8"); send(1, 64'h3DF, "R8"); send(1, 64'h3E0, "R8");
        // R10: memory request at a display I/O address
        send(0, 64'h3C0, "R10");
        // R9: I/O window beats display I/O
        io_base_reg = 8'h00; io_limit_reg = 8'h00; cmd_io_en = 1'b1;
        send(1, 64'h3C0, "R9");
        idle("R2"); idle("R2");
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule